// File: doc/BRIEF.md
# Moving-Average Speed Calculator

This block turns a stream of rotor period captures into a filtered speed reading. Each capture is a 16-bit count of timer ticks between position-sensor events, presented with a one-cycle valid strobe. A capture at or below a configured minimum count implies a speed above the allowed ceiling and is treated as a glitch: it is discarded. Accepted captures enter a circular buffer of 2^LOG2_DEPTH entries and a running sum is kept alongside. For each one the oldest entry leaves the sum and the new one enters it. The averaged period is the sum shifted right by LOG2_DEPTH.

The speed in rpm is a configured constant divided by the averaged period. The constant equals 60 × tick frequency × m ÷ (6 × pole pairs), with m the number of sensor edges per capture (1, 3 or 6). For example, a 24 MHz clock divided by 64, 2 pole pairs and m = 1 give 1 875 000. The minimum count is that constant divided by the highest speed to accept, so a 5000 rpm ceiling gives 375. The division is a 32-by-16 restoring divider that yields one quotient bit per cycle. A `done` strobe marks each fresh result. Until the buffer has received its first full set of entries, the reported speed is 0.

The sequencer has five states. `ST_IDLE` moves to `ST_UPDATE` when a capture is pending. `ST_UPDATE` writes the buffer and sum, then moves to `ST_START`. `ST_START` launches the divider and moves to `ST_DIVIDE` when the buffer is full; otherwise it moves straight to `ST_DONE`. `ST_DIVIDE` moves to `ST_DONE` when the divider finishes. `ST_DONE` registers the outputs and returns to `ST_IDLE`. A capture that arrives while the sequencer is busy waits in a one-entry holding register.

Top module: `spd_avg_calc`

## Requirements
- R1: When the buffer is full, `rpm` equals floor(`speed_const` / `avg_count`), reported with `done`.
- R2: A capture with `cap_count` <= `min_count` is discarded: no `done` follows it and it does not enter the average; `min_count`+1 is accepted.
- R3: `avg_count` equals floor(sum of the buffer entries / 2^LOG2_DEPTH), where empty entries count as zero.
- R4: The write pointer wraps after the last entry, so the average always covers the most recent 2^LOG2_DEPTH accepted captures.
- R5: `done` is high for exactly one cycle per accepted capture.
- R6: With the block idle, `done` for an accepted capture arrives within 40 clock cycles of the capture's valid cycle.
- R7: While fewer than 2^LOG2_DEPTH captures have been accepted since reset, `rpm` is reported as 0 and `avg_count` is still updated.
- R8: An accepted capture that arrives while a previous one is still being processed is held and then processed in turn. Each gets its own `done`, and neither is lost.
- R9: After reset, `avg_count`, `rpm` and `done` are 0, and the buffer and the sum are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | One-cycle strobe qualifying `cap_count` |
| cap_count | input | CAP_W | Period capture in timer ticks |
| speed_const | input | CONST_W | Numerator of the speed division |
| min_count | input | CAP_W | Rejection threshold; captures at or below it are discarded |
| avg_count | output | CAP_W | Averaged period of the latest result |
| rpm | output | CONST_W | Speed of the latest result |
| done | output | 1 | Pulses when `avg_count` and `rpm` are updated |

## Verification
The hardest situation to reach is a second capture landing while the divider is still iterating on the first. The holding register must then keep the second capture without disturbing the running sum. The bench forces this by issuing a capture a few cycles after a previous one, well inside the division window. It then checks both results in order against a software model of the buffer. A long sweep of pseudo-random periods, with deliberate threshold hits mixed in, wraps the pointer many times and compares every average and quotient arithmetically.

// File: rtl/spd_pkg.sv
package spd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UPDATE,
        ST_START,
        ST_DIVIDE,
        ST_DONE
    } calc_state_t;
endpackage

// File: rtl/spd_ring_sum.sv
module spd_ring_sum #(
    parameter int CAP_W      = 16,
    parameter int LOG2_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CAP_W-1:0] din,
    output logic [CAP_W-1:0] avg,
    output logic             full
);
    localparam int DEPTH = 1 << LOG2_DEPTH;
    localparam int SUM_W = CAP_W + LOG2_DEPTH;
    localparam logic [LOG2_DEPTH-1:0] PTR_ONE  = 1;
    localparam logic [LOG2_DEPTH-1:0] PTR_LAST = '1;
    localparam logic [LOG2_DEPTH:0]   FILL_MAX = (LOG2_DEPTH+1)'(DEPTH);

    logic [CAP_W-1:0]      mem [DEPTH];
    logic [LOG2_DEPTH-1:0] ptr;
    logic [LOG2_DEPTH:0]   fill;
    logic [SUM_W-1:0]      sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            ptr  <= '0;
            fill <= '0;
            sum  <= '0;
        end else if (wr_en) begin
            sum      <= sum - SUM_W'(mem[ptr]) + SUM_W'(din);
            mem[ptr] <= din;
            ptr      <= ptr + PTR_ONE;
            if (fill != FILL_MAX) fill <= fill + 1'b1;
        end
    end

    assign avg  = sum[LOG2_DEPTH +: CAP_W];
    assign full = (fill == FILL_MAX);

    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == PTR_LAST) |=> (ptr == '0));

    assert_sum_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sum));

    assert_fill_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> full);
endmodule

// File: rtl/spd_restoring_div.sv
module spd_restoring_div #(
    parameter int N_W = 32,
    parameter int D_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic [N_W-1:0] quotient,
    output logic           done
);
    localparam int CNT_W = $clog2(N_W + 1);

    logic [N_W-1:0]   dnd_q;
    logic [D_W-1:0]   dsr_q;
    logic [D_W-1:0]   rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [D_W:0]     trial;
    logic             fits;

    always_comb begin
        trial = {rem_q, quotient[N_W-1]};
        fits  = (trial >= {1'b0, dsr_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dnd_q    <= '0;
            dsr_q    <= '0;
            rem_q    <= '0;
            cnt_q    <= '0;
            busy_q   <= 1'b0;
            quotient <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                dnd_q    <= dividend;
                dsr_q    <= divisor;
                quotient <= dividend;
                rem_q    <= '0;
                cnt_q    <= CNT_W'(N_W);
                busy_q   <= 1'b1;
            end else if (busy_q) begin
                if (fits) begin
                    rem_q    <= D_W'(trial - {1'b0, dsr_q});
                    quotient <= {quotient[N_W-2:0], 1'b1};
                end else begin
                    rem_q    <= trial[D_W-1:0];
                    quotient <= {quotient[N_W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assert_div_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dsr_q != '0) |->
        (({{D_W{1'b0}}, quotient} * {{N_W{1'b0}}, dsr_q}) + {{N_W{1'b0}}, rem_q}
            == {{D_W{1'b0}}, dnd_q}));

    assert_div_rem_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dsr_q != '0) |-> (rem_q < dsr_q));

    assert_div_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/spd_avg_calc.sv
module spd_avg_calc
    import spd_pkg::*;
#(
    parameter int CAP_W      = 16,
    parameter int CONST_W    = 32,
    parameter int LOG2_DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_valid,
    input  logic [CAP_W-1:0]   cap_count,
    input  logic [CONST_W-1:0] speed_const,
    input  logic [CAP_W-1:0]   min_count,
    output logic [CAP_W-1:0]   avg_count,
    output logic [CONST_W-1:0] rpm,
    output logic               done
);
    calc_state_t state, state_nx;

    logic               accept;
    logic               pend_valid;
    logic [CAP_W-1:0]   pend_val;
    logic               buf_wr;
    logic [CAP_W-1:0]   buf_avg;
    logic               buf_full;
    logic               div_start;
    logic               div_done;
    logic [CONST_W-1:0] div_quo;

    assign accept = cap_valid && (cap_count > min_count);

    // holding register: one capture waits while the sequencer is busy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_val   <= '0;
        end else if (accept) begin
            pend_valid <= 1'b1;
            pend_val   <= cap_count;
        end else if (state == ST_IDLE && pend_valid) begin
            pend_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (pend_valid) state_nx = ST_UPDATE;
            ST_UPDATE: state_nx = ST_START;
            ST_START:  state_nx = buf_full ? ST_DIVIDE : ST_DONE;
            ST_DIVIDE: if (div_done) state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    logic [CAP_W-1:0] upd_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_val <= '0;
        else if (state == ST_IDLE && pend_valid) upd_val <= pend_val;
    end

    assign buf_wr    = (state == ST_UPDATE);
    assign div_start = (state == ST_START) && buf_full;

    spd_ring_sum #(
        .CAP_W      (CAP_W),
        .LOG2_DEPTH (LOG2_DEPTH)
    ) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (buf_wr),
        .din   (upd_val),
        .avg   (buf_avg),
        .full  (buf_full)
    );

    spd_restoring_div #(
        .N_W (CONST_W),
        .D_W (CAP_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (speed_const),
        .divisor  (buf_avg),
        .quotient (div_quo),
        .done     (div_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            avg_count <= '0;
            rpm       <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_DONE) begin
                avg_count <= buf_avg;
                rpm       <= buf_full ? div_quo : '0;
                done      <= 1'b1;
            end
        end
    end

    assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_count <= min_count && !pend_valid) |=> !pend_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && state != ST_IDLE) |=> pend_valid);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_zero_partial_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !buf_full) |-> (rpm == '0));

    assert_div_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIVIDE && !div_done) |=> (state == ST_DIVIDE));
endmodule

// File: tb/spd_avg_calc_bench.sv
module spd_avg_calc_bench;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0;
    logic [15:0] cap_count = '0;
    logic [31:0] speed_const = 32'd1875000;
    logic [15:0] min_count = 16'd375;
    logic [15:0] avg_count;
    logic [31:0] rpm;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;

    // software model of the buffer
    int m_buf [DEPTH];
    int m_ptr  = 0;
    int m_fill = 0;
    longint m_sum = 0;

    always #4 clk = ~clk;

    spd_avg_calc u_spd_avg_calc (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_valid   (cap_valid),
        .cap_count   (cap_count),
        .speed_const (speed_const),
        .min_count   (min_count),
        .avg_count   (avg_count),
        .rpm         (rpm),
        .done        (done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_push(input int v);
        m_sum = m_sum - m_buf[m_ptr] + v;
        m_buf[m_ptr] = v;
        m_ptr = (m_ptr + 1) % DEPTH;
        if (m_fill < DEPTH) m_fill++;
    endtask

    task automatic send_cap(input int v);
        @(negedge clk);
        cap_valid = 1'b1;
        cap_count = 16'(v);
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic wait_done(input int limit, output int lat, output bit seen);
        seen = 1'b0;
        lat  = 1;
        for (int c = 0; c < limit; c++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_result(input string tag);
        longint e_avg, e_rpm;
        e_avg = m_sum / DEPTH;
        e_rpm = (m_fill < DEPTH || e_avg == 0) ? 0 : longint'(speed_const) / e_avg;
        check(avg_count == 16'(e_avg), {tag, " R3 avg"}, avg_count, e_avg);
        if (m_fill < DEPTH) check(rpm == 0, {tag, " R7 rpm zero"}, rpm, 0);
        else check(rpm == 32'(e_rpm), {tag, " R1 R4 rpm"}, rpm, e_rpm);
        @(negedge clk);
        check(done == 1'b0, {tag, " R5 pulse width"}, done, 0);
    endtask

    task automatic accepted(input int v, input string tag);
        int lat;
        bit seen;
        send_cap(v);
        model_push(v);
        wait_done(60, lat, seen);
        check(seen && lat <= 40, {tag, " R6 latency"}, lat, 40);
        if (seen) check_result(tag);
    endtask

    task automatic rejected(input int v);
        bit any = 1'b0;
        send_cap(v);
        for (int c = 0; c < 60; c++) begin
            if (done) any = 1'b1;
            @(negedge clk);
        end
        check(!any, "R2 no done for rejected capture", any, 0);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int lat;
        bit seen;
        for (int i = 0; i < DEPTH; i++) m_buf[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(avg_count == 0, "R9 reset avg", avg_count, 0);
        check(rpm == 0, "R9 reset rpm", rpm, 0);
        check(done == 0, "R9 reset done", done, 0);

        // R7 partial fill, then first full set
        accepted(1000, "fill1");
        accepted(2000, "fill2");
        accepted(3000, "fill3");
        accepted(4000, "fill4");

        // R2 boundary: threshold rejected, threshold+1 accepted
        rejected(375);
        rejected(10);
        accepted(376, "R2 threshold+1");

        // R8 capture arriving during a division
        send_cap(5000);
        model_push(5000);
        repeat (5) @(negedge clk);
        send_cap(700);
        wait_done(60, lat, seen);
        check(seen, "R8 first done", seen, 1);
        if (seen) check_result("R8 first");
        model_push(700);
        wait_done(80, lat, seen);
        check(seen, "R8 held capture done", seen, 1);
        if (seen) check_result("R8 second");

        // sweep with wraps, rejected values and constant changes
        for (int i = 0; i < 300; i++) begin
            int v;
            if (i == 100) speed_const = 32'd5625000;
            if (i == 200) speed_const = 32'hFFFF_FFFF;
            v = 376 + ((i * 7919 + 13) % 65000);
            if (i % 17 == 5) rejected(1 + (i % 375));
            else accepted(v, "sweep");
        end

        // extremes of the period range
        accepted(16'hFFFF, "max");
        accepted(16'hFFFF, "max");
        accepted(16'hFFFF, "max");
        accepted(16'hFFFF, "max");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule